// File: doc/BRIEF.md
# Reloadable Down-Counting Event Counter

This block is a down counter that takes one step for every qualifying event and, when it steps past zero, reloads itself from a separate reload register and keeps going. A programmed value n therefore divides the event stream by n+1. Events come either from edges on an external input, filtered by a selectable edge polarity, or from the underflow pulse of a neighbouring timer, so several counters can be chained into a longer divider.

Software programs a small configuration register (operating mode, edge polarity, event source), writes the count value through a dedicated write port and controls counting with a run level. Where a count write lands depends on whether the first event after starting has been counted: before that it primes both the reload register and the live counter, after it only the reload register changes and the new value reaches the counter at the next underflow. Each underflow produces a one-cycle pulse for chaining and a one-cycle interrupt request.

Top module: `evt_down_counter`

## Requirements
- R1: While running in event mode (mode field cfg[1:0] = 01, run = 1), each qualifying event decrements the counter by one.
- R2: An event that arrives while the counter is 0 loads the reload register value instead, so a programmed n gives one underflow per n+1 events; with n = 0 every event underflows and the counter stays 0.
- R3: With the external input as source, edge field cfg[3:2] selects the counted edges: 00 falling, 01 rising, 10 both.
- R4: With edge field 11 and the external input as source, no external edge changes the counter.
- R5: With source bit cfg[4] = 1, every clock cycle in which the chain input is high is one event and the edge field has no effect.
- R6: A count write while stopped, or after start before the first event is counted, sets both the counter and the reload register to the written value.
- R7: Once the first event after start has been counted, a count write changes only the reload register; the counter keeps its value until the next underflow loads the new value.
- R8: While run = 0 the counter holds its value regardless of events.
- R9: Each underflow raises uf_pulse_out and irq_out for exactly one cycle, the same cycle in which the counter shows the reloaded value.
- R10: With a mode field other than 01, no event changes the counter.
- R11: Clearing run re-arms first-event tracking, so after the next start a count write again sets both counter and reload register.
- R12: cnt_rd_data always shows the live counter; after reset it reads 0 with both pulse outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wr_data | input | 8 | Configuration value: [1:0] mode, [3:2] edge select, [4] source select |
| run | input | 1 | Count enable level |
| cnt_wr_en | input | 1 | Count register write strobe |
| cnt_wr_data | input | CNT_W (16) | Count value to write |
| cnt_rd_data | output | CNT_W (16) | Live counter value |
| ext_evt_in | input | 1 | External event input, asynchronous |
| chain_uf_in | input | 1 | Underflow pulse from the neighbouring timer |
| uf_pulse_out | output | 1 | One-cycle underflow pulse for chaining |
| irq_out | output | 1 | One-cycle interrupt request on underflow |

## Verification
The hardest situation to reach is the split in write routing: the same write must land in both registers before the first counted event and only in the reload register afterwards, and the deferred value must surface exactly at the next underflow. The stimulus reaches it by starting the counter, writing before any edge, counting a few edges, writing again, and then driving the counter through zero so the deferred value appears; a later stop and restart shows the tracking re-armed. Edge polarity is covered by full pulses under each code, where a pulse carries one edge of each kind, and the divide-by-one case by chained pulses with n = 0.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;

   typedef enum logic [1:0] {
      EDGE_FALL = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_BOTH = 2'b10,
      EDGE_NONE = 2'b11
   } edge_sel_e;

   localparam logic [1:0] MODE_EVENT = 2'b01;
   localparam int unsigned CFG_BITS = 5;

   typedef struct packed {
      logic      src_chain;
      edge_sel_e edge_sel;
      logic [1:0] mode;
   } cfg_t;

endpackage

// File: rtl/evtcnt_edge_qual.sv
module evtcnt_edge_qual
   import evtcnt_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin_in,
   input  edge_sel_e edge_sel,
   output logic      qual_o
);

   localparam int unsigned LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   rise_w;
   logic                   fall_w;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("evtcnt_edge_qual: SYNC_STAGES must be at least 2");
      end
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= pin_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 1'b0;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[LAST];
   end

   assign rise_w =  sync_q[LAST] & ~prev_q;
   assign fall_w = ~sync_q[LAST] &  prev_q;

   always_comb begin
      unique case (edge_sel)
         EDGE_FALL: qual_o = fall_w;
         EDGE_RISE: qual_o = rise_w;
         EDGE_BOTH: qual_o = rise_w | fall_w;
         default:   qual_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/evtcnt_src_sel.sv
module evtcnt_src_sel
   import evtcnt_pkg::*;
#(
   parameter bit CHAIN_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  cfg_t cfg,
   input  logic run,
   input  logic ext_qual,
   input  logic chain_in,
   output logic evt_en
);

   logic chain_w;
   logic src_evt_w;

   generate
      if (CHAIN_REG) begin : g_chain_reg
         logic chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= 1'b0;
            else        chain_q <= chain_in;
         end
         assign chain_w = chain_q;
      end else begin : g_chain_direct
         assign chain_w = chain_in;
      end
   endgenerate

   assign src_evt_w = cfg.src_chain ? chain_w : ext_qual;
   assign evt_en    = run && (cfg.mode == MODE_EVENT) && src_evt_w;

endmodule

// File: rtl/evtcnt_core.sv
module evtcnt_core #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             evt_en,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt_o,
   output logic             armed_o,
   output logic             uf_o
);

   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] reload_nxt;
   logic             armed_q;
   logic             uf_q;
   logic             at_zero;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("evtcnt_core: CNT_W must be at least 2");
      end
   endgenerate

   assign at_zero    = (cnt_q == ZERO);
   assign reload_nxt = wr_en ? wr_data : reload_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= ZERO;
         reload_q <= ZERO;
         armed_q  <= 1'b0;
         uf_q     <= 1'b0;
      end else begin
         uf_q     <= 1'b0;
         reload_q <= reload_nxt;
         if (wr_en && !armed_q) begin
            cnt_q <= wr_data;
         end else if (evt_en) begin
            if (at_zero) begin
               cnt_q <= reload_nxt;
               uf_q  <= 1'b1;
            end else begin
               cnt_q <= cnt_q - ONE;
            end
         end
         if (!run)        armed_q <= 1'b0;
         else if (evt_en) armed_q <= 1'b1;
      end
   end

   assign cnt_o   = cnt_q;
   assign armed_o = armed_q;
   assign uf_o    = uf_q;

endmodule

// File: rtl/evt_down_counter.sv
module evt_down_counter
   import evtcnt_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned CFG_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          CHAIN_REG   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr_en,
   input  logic [CFG_W-1:0] cfg_wr_data,
   input  logic             run,
   input  logic             cnt_wr_en,
   input  logic [CNT_W-1:0] cnt_wr_data,
   output logic [CNT_W-1:0] cnt_rd_data,
   input  logic             ext_evt_in,
   input  logic             chain_uf_in,
   output logic             uf_pulse_out,
   output logic             irq_out
);

   generate
      if (CFG_W < CFG_BITS) begin : g_bad_cfg
         $error("evt_down_counter: CFG_W too narrow for configuration fields");
      end
   endgenerate

   cfg_t cfg_q;
   logic ext_qual;
   logic evt_en;
   logic armed;
   logic uf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cfg_q <= '0;
      else if (cfg_wr_en) cfg_q <= cfg_t'(cfg_wr_data[CFG_BITS-1:0]);
   end

   evtcnt_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   (ext_evt_in),
      .edge_sel (cfg_q.edge_sel),
      .qual_o   (ext_qual)
   );

   evtcnt_src_sel #(.CHAIN_REG(CHAIN_REG)) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (cfg_q),
      .run      (run),
      .ext_qual (ext_qual),
      .chain_in (chain_uf_in),
      .evt_en   (evt_en)
   );

   evtcnt_core #(.CNT_W(CNT_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .evt_en  (evt_en),
      .wr_en   (cnt_wr_en),
      .wr_data (cnt_wr_data),
      .cnt_o   (cnt_rd_data),
      .armed_o (armed),
      .uf_o    (uf)
   );

   assign uf_pulse_out = uf;
   assign irq_out      = uf;

endmodule

// File: rtl/evtcnt_checker.sv
module evtcnt_checker #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             cnt_wr_en,
   input logic [CNT_W-1:0] cnt_wr_data,
   input logic [CNT_W-1:0] cnt_rd_data,
   input logic             evt_en,
   input logic             armed,
   input logic [1:0]       cfg_mode,
   input logic [1:0]       cfg_edge,
   input logic             cfg_src,
   input logic             uf_pulse_out
);

   // R1: plain decrement on an event away from zero
   a_r1_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_en && !cnt_wr_en && cnt_rd_data != '0) |=>
         cnt_rd_data == CNT_W'($past(cnt_rd_data) - 1'b1));

   // R4: forbidden edge code on the external source freezes the count
   a_r4_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_edge == 2'b11 && !cfg_src && !cnt_wr_en) |=> $stable(cnt_rd_data));

   // R6: write before the first event lands in the counter
   a_r6_prime_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr_en && !armed) |=> cnt_rd_data == $past(cnt_wr_data));

   // R7: write after the first event leaves the counter alone
   a_r7_reload_only: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr_en && armed && !evt_en) |=> $stable(cnt_rd_data));

   // R8: halted counter holds
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr_en) |=> $stable(cnt_rd_data));

   // R9: an underflow pulse follows a counter at zero
   a_r9_uf_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
      uf_pulse_out |-> $past(cnt_rd_data) == '0);

   // R10: other modes never count
   a_r10_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode != 2'b01 && !cnt_wr_en) |=> $stable(cnt_rd_data));

endmodule

bind evt_down_counter evtcnt_checker #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .run          (run),
   .cnt_wr_en    (cnt_wr_en),
   .cnt_wr_data  (cnt_wr_data),
   .cnt_rd_data  (cnt_rd_data),
   .evt_en       (evt_en),
   .armed        (armed),
   .cfg_mode     (cfg_q.mode),
   .cfg_edge     (cfg_q.edge_sel),
   .cfg_src      (cfg_q.src_chain),
   .uf_pulse_out (uf_pulse_out)
);

// File: tb/evt_down_counter_tb.sv
module evt_down_counter_tb;

   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_wr_en = 1'b0;
   logic [7:0]       cfg_wr_data = '0;
   logic             run = 1'b0;
   logic             cnt_wr_en = 1'b0;
   logic [CNT_W-1:0] cnt_wr_data = '0;
   logic [CNT_W-1:0] cnt_rd_data;
   logic             ext_evt_in = 1'b0;
   logic             chain_uf_in = 1'b0;
   logic             uf_pulse_out;
   logic             irq_out;

   int checks = 0;
   int fails  = 0;
   int uf_seen = 0;
   bit done = 1'b0;

   typedef struct {
      logic [CNT_W-1:0] val;
      string            tag;
   } exp_t;
   exp_t exp_q[$];

   always #10 clk = ~clk;

   evt_down_counter u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_wr_en    (cfg_wr_en),
      .cfg_wr_data  (cfg_wr_data),
      .run          (run),
      .cnt_wr_en    (cnt_wr_en),
      .cnt_wr_data  (cnt_wr_data),
      .cnt_rd_data  (cnt_rd_data),
      .ext_evt_in   (ext_evt_in),
      .chain_uf_in  (chain_uf_in),
      .uf_pulse_out (uf_pulse_out),
      .irq_out      (irq_out)
   );

   // monitor: pops expected counts, tracks pulse outputs (R9)
   always @(negedge clk) begin
      if (rst_n) begin
         if (uf_pulse_out) uf_seen++;
         if (irq_out !== uf_pulse_out) begin
            checks++; fails++;
            $display("FAIL R9 irq_out=%0b uf_pulse_out=%0b", irq_out, uf_pulse_out);
         end
      end
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         checks++;
         if (cnt_rd_data !== e.val) begin
            fails++;
            $display("FAIL %s count actual=%0d expected=%0d", e.tag, cnt_rd_data, e.val);
         end
      end
   end

   task automatic expect_cnt(input logic [CNT_W-1:0] v, input string tag);
      exp_t e;
      e.val = v; e.tag = tag;
      exp_q.push_back(e);
      repeat (2) @(negedge clk);
   endtask

   task automatic expect_uf(input int v, input string tag);
      checks++;
      if (uf_seen != v) begin
         fails++;
         $display("FAIL %s underflows actual=%0d expected=%0d", tag, uf_seen, v);
      end
   endtask

   task automatic wr_cfg(input logic [7:0] d);
      @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = d;
      @(negedge clk); cfg_wr_en = 1'b0;
   endtask

   task automatic wr_cnt(input logic [CNT_W-1:0] d);
      @(negedge clk); cnt_wr_en = 1'b1; cnt_wr_data = d;
      @(negedge clk); cnt_wr_en = 1'b0;
   endtask

   task automatic ext_pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ext_evt_in = 1'b1;
         repeat (5) @(negedge clk);
         ext_evt_in = 1'b0;
         repeat (5) @(negedge clk);
      end
   endtask

   task automatic chain_pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); chain_uf_in = 1'b1;
         @(negedge clk); chain_uf_in = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic set_run(input logic r);
      @(negedge clk); run = r;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12: reset state
      checks++;
      if (uf_pulse_out !== 1'b0 || irq_out !== 1'b0) begin
         fails++;
         $display("FAIL R12 pulses actual=%0b%0b expected=00", uf_pulse_out, irq_out);
      end
      expect_cnt(16'd0, "R12");

      wr_cfg(8'h05);              // mode 01, rising, external
      wr_cnt(16'd5);
      expect_cnt(16'd5, "R6");    // stopped: both registers
      set_run(1'b1);
      wr_cnt(16'd7);
      expect_cnt(16'd7, "R6");    // started, no event yet
      ext_pulse(3);
      expect_cnt(16'd4, "R1");    // R3 rising edges
      wr_cnt(16'd2);
      expect_cnt(16'd4, "R7");    // reload only
      ext_pulse(4);
      expect_cnt(16'd0, "R1");
      ext_pulse(1);
      expect_cnt(16'd2, "R7");    // deferred value on underflow (R2)
      expect_uf(1, "R9");

      set_run(1'b0);
      ext_pulse(2);
      expect_cnt(16'd2, "R8");
      wr_cnt(16'd9);
      expect_cnt(16'd9, "R6");
      set_run(1'b1);
      wr_cnt(16'd3);
      expect_cnt(16'd3, "R11");   // re-armed after stop

      wr_cfg(8'h01);              // falling
      ext_pulse(1);
      expect_cnt(16'd2, "R3");
      wr_cfg(8'h09);              // both
      ext_pulse(1);
      expect_cnt(16'd0, "R3");
      wr_cfg(8'h0D);              // code 11
      ext_pulse(2);
      expect_cnt(16'd0, "R4");
      expect_uf(1, "R4");

      wr_cfg(8'h1D);              // chain source, edge code ignored
      chain_pulse(1);
      expect_cnt(16'd3, "R5");
      expect_uf(2, "R9");
      chain_pulse(2);
      expect_cnt(16'd1, "R5");

      wr_cfg(8'h1C);              // mode 00
      chain_pulse(2);
      expect_cnt(16'd1, "R10");

      wr_cfg(8'h11);              // event mode, chain source
      set_run(1'b0);
      wr_cnt(16'd0);
      set_run(1'b1);
      chain_pulse(3);
      expect_cnt(16'd0, "R2");
      expect_uf(5, "R2");

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule